// File: doc/BRIEF.md
# SIMD Lane Condition Evaluator

This block decides a packed "unit" condition after an arithmetic or logical operation on a 64-bit register. It receives both source operands, the produced result, a 4-bit condition selector and a doubleword flag. From these it judges whether any byte or halfword lane of the result is zero, or whether a carry left a nibble, byte or halfword lane. The single-bit outcome is registered on a valid strobe.

The zero-lane tests use a borrow trick. A lane-LSB pattern is subtracted from the result, the difference is masked by the inverted result, and then by a lane-MSB pattern. A set bit that survives means some lane was zero. The carry tests build a per-bit carry-out vector from the operands and the result, then mask it at the top bit of each lane. In word mode the patterns cover only bits 31:0, so the upper half of every input plays no part. In doubleword mode the same patterns are repeated in both 32-bit halves.

Top module: `simd_lane_cond`

## Requirements
- R1: While `rst_n` is low, `cond_o` is cleared to 0 at each clock edge.
- R2: `cond_o` changes only at a clock edge where `valid_i` is high. Otherwise it holds its value.
- R3: When `cond_i[3:1]` = 2, the raw outcome is 1 if any 8-bit lane of the tested span of `res_i` equals zero.
- R4: When `cond_i[3:1]` = 3, the raw outcome is 1 if any 16-bit lane of the tested span of `res_i` equals zero.
- R5: When `cond_i[3:1]` = 4, the raw outcome is 1 if a carry leaves any bit position 4k+3 in the span. The carry out of bit i is (a&b)|((a|b)&~res) at bit i, which for res = a+b is the true carry.
- R6: When `cond_i[3:1]` = 6, the raw outcome is 1 if a carry leaves any bit position 8k+7 in the span.
- R7: When `cond_i[3:1]` = 7, the raw outcome is 1 if a carry leaves any bit position 16k+15 in the span.
- R8: `cond_i[0]` = 1 inverts the raw outcome of selectors 0, 2, 3, 4, 6 and 7.
- R9: Selector 0 means "never": it gives 0, or 1 when `cond_i[0]` is set.
- R10: Selectors 1 and 5 are reserved and always give 0, whatever the value of `cond_i[0]`.
- R11: With `dword_i` = 0 the span is bits 31:0, and bits 63:32 of all three data inputs have no effect. With `dword_i` = 1 the span is all 64 bits.
- R12: The outcome for the inputs presented with `valid_i` high appears on `cond_o` right after that clock edge, not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the outcome register |
| dword_i | input | 1 | 1 = test all 64 bits, 0 = test bits 31:0 only |
| cond_i | input | 4 | Bits 3:1 select the test, bit 0 inverts it |
| op_a_i | input | DATA_W | First operand of the producing operation |
| op_b_i | input | DATA_W | Second operand of the producing operation |
| res_i | input | DATA_W | Result of the producing operation |
| cond_o | output | 1 | Registered condition outcome |

## Verification
The carry properties assume the operands and result are stable and consistent in the cycle `valid_i` is high. They use only the case where both operands have the lane top bit set, since that forces a carry whatever the result holds. The bench drives every input at the falling edge and keeps it steady across the capturing rising edge. For all carry scenarios it presents res = a + b, so its reference can take carries from a real addition of the low operand bits.

// File: rtl/lane_cond_pkg.sv
package lane_cond_pkg;

   typedef enum logic [2:0] {
      TST_NEVER  = 3'd0,
      TST_RSV1   = 3'd1,
      TST_ZBYTE  = 3'd2,
      TST_ZHALF  = 3'd3,
      TST_CDIGIT = 3'd4,
      TST_RSV5   = 3'd5,
      TST_CBYTE  = 3'd6,
      TST_CHALF  = 3'd7
   } test_e;

   function automatic logic test_is_reserved(test_e t);
      return (t == TST_RSV1) || (t == TST_RSV5);
   endfunction

endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32
) (
   input  logic              dword_i,
   output logic [DATA_W-1:0] byte_lsb_o,
   output logic [DATA_W-1:0] byte_msb_o,
   output logic [DATA_W-1:0] half_lsb_o,
   output logic [DATA_W-1:0] half_msb_o,
   output logic [DATA_W-1:0] digit_msb_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic en;
      if (i < WORD_W) begin : g_low
         assign en = 1'b1;
      end else begin : g_high
         assign en = dword_i;
      end
      assign byte_lsb_o[i]  = en & ((i % 8)  == 0);
      assign byte_msb_o[i]  = en & ((i % 8)  == 7);
      assign half_lsb_o[i]  = en & ((i % 16) == 0);
      assign half_msb_o[i]  = en & ((i % 16) == 15);
      assign digit_msb_o[i] = en & ((i % 4)  == 3);
   end
endmodule

// File: rtl/lane_zero_detect.sv
module lane_zero_detect #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic [DATA_W-1:0] lsb_i,
   input  logic [DATA_W-1:0] msb_i,
   output logic              hit_o
);
   logic [DATA_W-1:0] diff;
   logic [DATA_W-1:0] flagged;

   assign diff    = res_i - lsb_i;
   assign flagged = diff & ~res_i & msb_i;
   assign hit_o   = |flagged;
endmodule

// File: rtl/lane_carry_detect.sv
module lane_carry_detect #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] op_a_i,
   input  logic [DATA_W-1:0] op_b_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic [DATA_W-1:0] digit_msb_i,
   input  logic [DATA_W-1:0] byte_msb_i,
   input  logic [DATA_W-1:0] half_msb_i,
   output logic              digit_hit_o,
   output logic              byte_hit_o,
   output logic              half_hit_o
);
   logic [DATA_W-1:0] carry_vec;

   assign carry_vec   = (op_a_i & op_b_i) | ((op_a_i | op_b_i) & ~res_i);
   assign digit_hit_o = |(carry_vec & digit_msb_i);
   assign byte_hit_o  = |(carry_vec & byte_msb_i);
   assign half_hit_o  = |(carry_vec & half_msb_i);
endmodule

// File: rtl/simd_lane_cond.sv
module simd_lane_cond
   import lane_cond_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              dword_i,
   input  logic [3:0]        cond_i,
   input  logic [DATA_W-1:0] op_a_i,
   input  logic [DATA_W-1:0] op_b_i,
   input  logic [DATA_W-1:0] res_i,
   output logic              cond_o
);
   localparam int WORD_W = DATA_W / 2;

   if ((DATA_W % 32) != 0 || DATA_W < 32) begin : g_bad_width
      $error("simd_lane_cond: DATA_W must be a nonzero multiple of 32");
   end

   logic [DATA_W-1:0] byte_lsb, byte_msb, half_lsb, half_msb, digit_msb;
   logic              zbyte_hit, zhalf_hit;
   logic              cdigit_hit, cbyte_hit, chalf_hit;
   logic              raw_hit, next_cond;
   test_e             sel;

   lane_mask_gen #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_masks (
      .dword_i     (dword_i),
      .byte_lsb_o  (byte_lsb),
      .byte_msb_o  (byte_msb),
      .half_lsb_o  (half_lsb),
      .half_msb_o  (half_msb),
      .digit_msb_o (digit_msb)
   );

   lane_zero_detect #(.DATA_W(DATA_W)) u_zbyte (
      .res_i (res_i),
      .lsb_i (byte_lsb),
      .msb_i (byte_msb),
      .hit_o (zbyte_hit)
   );

   lane_zero_detect #(.DATA_W(DATA_W)) u_zhalf (
      .res_i (res_i),
      .lsb_i (half_lsb),
      .msb_i (half_msb),
      .hit_o (zhalf_hit)
   );

   lane_carry_detect #(.DATA_W(DATA_W)) u_carry (
      .op_a_i      (op_a_i),
      .op_b_i      (op_b_i),
      .res_i       (res_i),
      .digit_msb_i (digit_msb),
      .byte_msb_i  (byte_msb),
      .half_msb_i  (half_msb),
      .digit_hit_o (cdigit_hit),
      .byte_hit_o  (cbyte_hit),
      .half_hit_o  (chalf_hit)
   );

   always_comb begin
      sel = test_e'(cond_i[3:1]);
      unique case (sel)
         TST_ZBYTE:  raw_hit = zbyte_hit;
         TST_ZHALF:  raw_hit = zhalf_hit;
         TST_CDIGIT: raw_hit = cdigit_hit;
         TST_CBYTE:  raw_hit = cbyte_hit;
         TST_CHALF:  raw_hit = chalf_hit;
         default:    raw_hit = 1'b0;
      endcase
      next_cond = test_is_reserved(sel) ? 1'b0 : (raw_hit ^ cond_i[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_o <= 1'b0;
      end else if (valid_i) begin
         cond_o <= next_cond;
      end
   end
endmodule

// File: rtl/simd_lane_cond_chk.sv
module simd_lane_cond_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_i,
   input logic              dword_i,
   input logic [3:0]        cond_i,
   input logic [DATA_W-1:0] op_a_i,
   input logic [DATA_W-1:0] op_b_i,
   input logic [DATA_W-1:0] res_i,
   input logic              cond_o
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> !cond_o);

   assert_hold_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(cond_o));

   assert_byte0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 4'h4 && res_i[7:0] == 8'h00) |=> cond_o);

   assert_half_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 4'hE && op_a_i[15] && op_b_i[15]) |=> cond_o);

   assert_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 4'h0) |=> !cond_o);

   assert_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 4'h1) |=> cond_o);

   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (cond_i[3:1] == 3'd1 || cond_i[3:1] == 3'd5)) |=> !cond_o);

   assert_upper_carry_dword_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && dword_i && cond_i == 4'hC && op_a_i[DATA_W-1] && op_b_i[DATA_W-1]) |=> cond_o);
endmodule

bind simd_lane_cond simd_lane_cond_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid_i (valid_i),
   .dword_i (dword_i),
   .cond_i  (cond_i),
   .op_a_i  (op_a_i),
   .op_b_i  (op_b_i),
   .res_i   (res_i),
   .cond_o  (cond_o)
);

// File: tb/simd_lane_cond_bench.sv
`timescale 1ns/1ps
module simd_lane_cond_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic        dword_i = 1'b0;
   logic [3:0]  cond_i = 4'h0;
   logic [63:0] op_a_i = '0, op_b_i = '0, res_i = '0;
   logic        cond_o;
   int          checks = 0;
   int          errors = 0;

   simd_lane_cond #(.DATA_W(64)) u_simd_lane_cond (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dword_i(dword_i),
      .cond_i(cond_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .res_i(res_i),
      .cond_o(cond_o)
   );

   always #5 clk = ~clk;

   function automatic logic carry_at(logic [63:0] a, logic [63:0] b, int k);
      logic [64:0] m, s;
      m = (65'd1 << (k + 1)) - 65'd1;
      s = ({1'b0, a} & m) + ({1'b0, b} & m);
      return s[k+1];
   endfunction

   function automatic logic ref_eval(logic [3:0] c, logic dw, logic [63:0] a,
                                     logic [63:0] b, logic [63:0] r);
      int  span = dw ? 64 : 32;
      int  step;
      logic hit = 1'b0;
      case (c[3:1])
         3'd1, 3'd5: return 1'b0;
         3'd2: for (int l = 0; l < span / 8; l++)  if (r[l*8 +: 8] == 8'h00) hit = 1'b1;
         3'd3: for (int l = 0; l < span / 16; l++) if (r[l*16 +: 16] == 16'h0) hit = 1'b1;
         3'd4, 3'd6, 3'd7: begin
            step = (c[3:1] == 3'd4) ? 4 : (c[3:1] == 3'd6) ? 8 : 16;
            for (int k = step - 1; k < span; k += step) if (carry_at(a, b, k)) hit = 1'b1;
         end
         default: hit = 1'b0;
      endcase
      return hit ^ c[0];
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_eval(logic [3:0] c, logic dw, logic [63:0] a, logic [63:0] b,
                          logic [63:0] r, string req);
      @(negedge clk);
      cond_i = c; dword_i = dw; op_a_i = a; op_b_i = b; res_i = r; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check(req, cond_o, ref_eval(c, dw, a, b, r));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", cond_o, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_zero_byte;
      do_eval(4'h4, 1'b1, '0, '0, 64'h1111_1111_1111_1100, "R3 byte0 zero");
      do_eval(4'h4, 1'b1, '0, '0, 64'h0101_0101_0101_0101, "R3 no zero");
      do_eval(4'h4, 1'b1, '0, '0, 64'h8080_8080_8080_8080, "R3 msb bytes");
      do_eval(4'h4, 1'b1, '0, '0, 64'h0100_0101_0101_0101, "R3 byte6 zero");
      do_eval(4'h4, 1'b0, '0, '0, 64'hFFFF_FFFF_FF00_FFFF, "R3 word byte2");
   endtask

   task automatic t_zero_half;
      do_eval(4'h6, 1'b1, '0, '0, 64'h0101_0000_0101_0101, "R4 half2 zero");
      do_eval(4'h6, 1'b1, '0, '0, 64'h0100_0001_00FF_FF00, "R4 no zero half");
      do_eval(4'h6, 1'b0, '0, '0, 64'h1234_5678_0000_0001, "R4 word half1");
   endtask

   task automatic t_carries;
      do_eval(4'h8, 1'b1, 64'h8, 64'h8, 64'h10, "R5 digit carry");
      do_eval(4'h8, 1'b1, 64'h7, 64'h8, 64'hF, "R5 no digit carry");
      do_eval(4'hC, 1'b1, 64'h80, 64'h80, 64'h100, "R6 byte carry");
      do_eval(4'hC, 1'b1, 64'h8, 64'h8, 64'h10, "R6 digit only");
      do_eval(4'hE, 1'b1, 64'h8000, 64'h8000, 64'h1_0000, "R7 half carry");
      do_eval(4'hE, 1'b1, 64'h80, 64'h80, 64'h100, "R7 byte only");
      do_eval(4'hE, 1'b1, 64'hFFFF, 64'h1, 64'h1_0000, "R7 rippled carry");
   endtask

   task automatic t_invert;
      do_eval(4'h5, 1'b1, '0, '0, 64'h1111_1111_1111_1100, "R8 inv byte zero");
      do_eval(4'h7, 1'b1, '0, '0, 64'h0101_0101_0101_0101, "R8 inv half");
      do_eval(4'hD, 1'b1, 64'h80, 64'h80, 64'h100, "R8 inv byte carry");
   endtask

   task automatic t_never_reserved;
      do_eval(4'h0, 1'b1, '1, '1, '0, "R9 never");
      do_eval(4'h1, 1'b1, '0, '0, '1, "R9 always");
      do_eval(4'h2, 1'b1, '1, '1, '0, "R10 reserved 1");
      do_eval(4'h3, 1'b1, '1, '1, '0, "R10 reserved 1 inv");
      do_eval(4'hB, 1'b1, '1, '1, '0, "R10 reserved 5 inv");
   endtask

   task automatic t_word_mode;
      do_eval(4'h4, 1'b0, '0, '0, 64'h0000_0000_0101_0101, "R11 word ignores upper zero");
      do_eval(4'h4, 1'b1, '0, '0, 64'h0000_0000_0101_0101, "R11 dword sees upper zero");
      do_eval(4'h8, 1'b0, 64'h8_0000_0000, 64'h8_0000_0000, 64'h10_0000_0000, "R11 word upper carry");
      do_eval(4'h8, 1'b1, 64'h8_0000_0000, 64'h8_0000_0000, 64'h10_0000_0000, "R11 dword upper carry");
      do_eval(4'hE, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, '0, "R11 top half carry");
   endtask

   task automatic t_hold_and_latency;
      do_eval(4'h1, 1'b1, '0, '0, '0, "R2 preset one");
      @(negedge clk);
      cond_i = 4'h0; valid_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 hold without valid", cond_o, 1'b1);
      cond_i = 4'h0; valid_i = 1'b1;
      #1;
      check("R12 not before edge", cond_o, 1'b1);
      @(negedge clk);
      valid_i = 1'b0;
      check("R12 after edge", cond_o, 1'b0);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_zero_byte();
      t_zero_half();
      t_carries();
      t_invert();
      t_never_reserved();
      t_word_mode();
      t_hold_and_latency();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule